// File: doc/BRIEF.md
# Multi-Master Bus Arbiter

This block sits between one processor's local bus and a system bus that several masters share. It watches the processor's three-bit status code and decides whether the current cycle needs the shared bus. When a cycle does, it asks for the bus, waits until it has priority and the shared busy line is free, and then takes the bus. While the block owns the bus it holds the shared busy line low and enables the local address path. While it does not own the bus, the address enable stays inactive, so the local bus controller and latches float and the processor waits.

Ownership is sticky. The block keeps the bus until another master needs it or its own processor halts, and it hands the bus over only at a point where that is safe. The lock inputs and the straps decide where those points are. Priority comes in on a priority-in line and is passed down a daisy chain on a priority-out line. The two open-drain shared lines (busy and common request) appear as separate sense inputs and pull-enable outputs. All arbitration runs on the bus clock. Status is captured on the local clock and then passed through a synchroniser into the bus-clock domain.

Top module: `mm_bus_arbiter`

## Requirements
- R1: While `init_n` is low, and after it is released, the block does not own the bus: `breq_n`=1, `aen_n`=1, `busy_pull`=0 and `cbrq_pull`=0.
- R2: Status codes are decoded as follows: 111 passive, 011 halt, 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 100/101/110 memory. When the status moves from passive to a code that needs the bus and the block is idle, it drives `breq_n` low. It pulls the common-request line (`cbrq_pull`=1) while it waits.
- R3: A waiting block takes the bus only on a bus-clock edge where `prio_in_n` is low and `busy_in` is high. After that edge, `busy_pull`=1 and `aen_n`=0.
- R4: With priority held and no common request, the owner keeps the bus through passive periods. A halt code (011) makes it release the bus by itself.
- R5: An owner that loses priority (`prio_in_n` high) keeps the bus while a memory cycle is in progress. It releases the bus once the status is passive.
- R6: While `lock_n` is low, the owner never releases the bus, whatever other requests there are.
- R7: While `crqlck_n` is low, a low common-request line does not make the owner release the bus.
- R8: With `strap_anyreq`=1, a low common-request line makes the owner release the bus at the next passive status. With `strap_anyreq`=0, the owner keeps the bus across passive periods despite that request.
- R9: With `strap_iobus`=1, I/O and interrupt-acknowledge cycles do not request the bus. An owner may release the bus to a waiting requester during an I/O cycle.
- R10: With `strap_resident`=1, a cycle requests the bus only if `sysres_sel` is high, and the owner may release the bus while `sysres_sel` is low. With `strap_resident`=0, `sysres_sel` has no effect.
- R11: `prio_out_n` is low only while `prio_in_n` is low and the block is neither requesting nor owning the bus.
- R12: The owner never pulls the common-request line (`cbrq_pull`=0 while `busy_pull`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lclk | input | 1 | Processor clock; status is captured on it |
| bclk | input | 1 | Shared-bus clock; all arbitration is timed to it |
| init_n | input | 1 | Active-low initialise, asynchronous reset |
| proc_status | input | 3 | Processor status code |
| lock_n | input | 1 | Active-low lock: no release at all |
| crqlck_n | input | 1 | Active-low: ignore common requests |
| strap_iobus | input | 1 | Only memory cycles use the shared bus |
| strap_resident | input | 1 | Use `sysres_sel` to pick the shared bus |
| strap_anyreq | input | 1 | Treat common requests like higher priority |
| sysres_sel | input | 1 | High: current access targets the shared bus |
| prio_in_n | input | 1 | Active-low priority granted to this block |
| prio_out_n | output | 1 | Active-low priority passed down the chain |
| breq_n | output | 1 | Active-low bus request |
| busy_in | input | 1 | Level of the wired busy line (low = bus taken) |
| busy_pull | output | 1 | Pull the busy line low |
| cbrq_in | input | 1 | Level of the wired common-request line |
| cbrq_pull | output | 1 | Pull the common-request line low |
| aen_n | output | 1 | Active-low address enable to the local bus |

## Verification
The hardest situation to reach is an owner that has lost priority, or sees a common request, while a cycle is still in progress. The bench must show that the release waits for the right status and is not taken at once. To get there, the bench first gets the bus through a normal request. It then holds the status on an active memory code while it raises `prio_in_n`, or while it changes the lock or strap inputs. Only after checking that the bus is still held does it return the status to passive, or move it to an I/O code, or drop `sysres_sel`, and check the release.

// File: rtl/mmarb_pkg.sv
package mmarb_pkg;

  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_INTA    = 3'b000,
    ST_IORD    = 3'b001,
    ST_IOWR    = 3'b010,
    ST_HALT    = 3'b011,
    ST_FETCH   = 3'b100,
    ST_MRD     = 3'b101,
    ST_MWR     = 3'b110,
    ST_PASSIVE = 3'b111
  } proc_status_e;

  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_WAIT = 2'd1,
    OWN_HOLD = 2'd2
  } own_state_e;

  function automatic logic st_is_memory(logic [ST_W-1:0] s);
    return s[ST_W-1] && (s != ST_PASSIVE);
  endfunction

  // interrupt acknowledge counts as an I/O cycle
  function automatic logic st_is_io(logic [ST_W-1:0] s);
    return !s[ST_W-1] && (s != ST_HALT);
  endfunction

  function automatic logic st_wants_bus(logic [ST_W-1:0] s, logic iob,
                                        logic resident, logic sel);
    if (s == ST_PASSIVE || s == ST_HALT) return 1'b0;
    if (iob && !st_is_memory(s))         return 1'b0;
    if (resident && !sel)                return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic st_may_yield(logic [ST_W-1:0] s, logic iob,
                                        logic resident, logic sel);
    return (s == ST_PASSIVE) || (iob && st_is_io(s)) || (resident && !sel);
  endfunction

endpackage

// File: rtl/mmarb_status_sync.sv
module mmarb_status_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         lclk,
  input  logic         bclk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0]             cap_q;
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge lclk or negedge rst_n) begin
    if (!rst_n) cap_q <= RST_VAL;
    else        cap_q <= d;
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= cap_q;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/mmarb_cycle_track.sv
module mmarb_cycle_track
  import mmarb_pkg::*;
(
  input  logic            bclk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] st,
  output logic            cyc_start,
  output logic            cyc_passive,
  output logic            cyc_halt
);

  logic [ST_W-1:0] st_prev_q;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) st_prev_q <= ST_PASSIVE;
    else        st_prev_q <= st;
  end

  assign cyc_start   = (st_prev_q == ST_PASSIVE) && (st != ST_PASSIVE);
  assign cyc_passive = (st == ST_PASSIVE);
  assign cyc_halt    = (st == ST_HALT);

endmodule

// File: rtl/mmarb_own_fsm.sv
module mmarb_own_fsm
  import mmarb_pkg::*;
(
  input  logic       bclk,
  input  logic       rst_n,
  input  logic       cyc_start,
  input  logic       cyc_passive,
  input  logic       cyc_halt,
  input  logic       need_bus,
  input  logic       may_yield,
  input  logic       grant_n,
  input  logic       busy_line,
  input  logic       cbrq_line,
  input  logic       lock_n,
  input  logic       crqlck_n,
  input  logic       any_rq,
  output own_state_e state,
  output logic       take_ev,
  output logic       drop_ev
);

  own_state_e state_q, state_d;
  logic lost_prio, cbrq_ask, yield_cbrq;

  assign lost_prio  = grant_n;
  assign cbrq_ask   = !cbrq_line && crqlck_n;
  // without any-request, a lower requester waits for a non-passive yield point
  assign yield_cbrq = cbrq_ask && may_yield && (any_rq || !cyc_passive);

  assign take_ev = (state_q == OWN_WAIT) && !grant_n && busy_line;
  assign drop_ev = (state_q == OWN_HOLD) && lock_n &&
                   (cyc_halt || (lost_prio && may_yield) || yield_cbrq);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      OWN_IDLE: if (cyc_start && need_bus) state_d = OWN_WAIT;
      OWN_WAIT: if (take_ev)               state_d = OWN_HOLD;
      OWN_HOLD: if (drop_ev)               state_d = OWN_IDLE;
      default:                             state_d = OWN_IDLE;
    endcase
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) state_q <= OWN_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/mm_bus_arbiter.sv
module mm_bus_arbiter
  import mmarb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            lclk,
  input  logic            bclk,
  input  logic            init_n,
  input  logic [ST_W-1:0] proc_status,
  input  logic            lock_n,
  input  logic            crqlck_n,
  input  logic            strap_iobus,
  input  logic            strap_resident,
  input  logic            strap_anyreq,
  input  logic            sysres_sel,
  input  logic            prio_in_n,
  output logic            prio_out_n,
  output logic            breq_n,
  input  logic            busy_in,
  output logic            busy_pull,
  input  logic            cbrq_in,
  output logic            cbrq_pull,
  output logic            aen_n
);

  logic [ST_W-1:0] st_sync;
  logic            st_start, st_passive, st_halt;
  logic            need_bus, may_yield;
  logic            take_ev, drop_ev;
  own_state_e      own_state;

  mmarb_status_sync #(
    .W(ST_W), .STAGES(SYNC_STAGES), .RST_VAL(ST_PASSIVE)
  ) i_sync (
    .lclk(lclk), .bclk(bclk), .rst_n(init_n), .d(proc_status), .q(st_sync)
  );

  mmarb_cycle_track i_track (
    .bclk(bclk), .rst_n(init_n), .st(st_sync),
    .cyc_start(st_start), .cyc_passive(st_passive), .cyc_halt(st_halt)
  );

  assign need_bus  = st_wants_bus(st_sync, strap_iobus, strap_resident, sysres_sel);
  assign may_yield = st_may_yield(st_sync, strap_iobus, strap_resident, sysres_sel);

  mmarb_own_fsm i_fsm (
    .bclk(bclk), .rst_n(init_n),
    .cyc_start(st_start), .cyc_passive(st_passive), .cyc_halt(st_halt),
    .need_bus(need_bus), .may_yield(may_yield),
    .grant_n(prio_in_n), .busy_line(busy_in), .cbrq_line(cbrq_in),
    .lock_n(lock_n), .crqlck_n(crqlck_n), .any_rq(strap_anyreq),
    .state(own_state), .take_ev(take_ev), .drop_ev(drop_ev)
  );

  assign breq_n     = (own_state == OWN_IDLE);
  assign busy_pull  = (own_state == OWN_HOLD);
  assign aen_n      = (own_state != OWN_HOLD);
  assign cbrq_pull  = (own_state == OWN_WAIT);
  assign prio_out_n = !(!prio_in_n && own_state == OWN_IDLE);

endmodule

// File: rtl/mm_bus_arbiter_chk.sv
module mm_bus_arbiter_chk (
  input logic bclk,
  input logic init_n,
  input logic lock_n,
  input logic prio_in_n,
  input logic prio_out_n,
  input logic breq_n,
  input logic busy_in,
  input logic busy_pull,
  input logic cbrq_in,
  input logic cbrq_pull,
  input logic aen_n,
  input logic st_halt
);

  AST_TAKE_NEEDS_GRANT: assert property (@(posedge bclk) disable iff (!init_n)
    $rose(busy_pull) |-> $past(!prio_in_n && busy_in && !breq_n)); // R3

  AST_AEN_ONLY_OWNED: assert property (@(posedge bclk) disable iff (!init_n)
    !aen_n |-> busy_pull); // R3

  AST_CBRQ_WHILE_ASKING: assert property (@(posedge bclk) disable iff (!init_n)
    cbrq_pull |-> !breq_n); // R2

  AST_NO_VOLUNTARY_DROP: assert property (@(posedge bclk) disable iff (!init_n)
    (busy_pull && !prio_in_n && cbrq_in && !st_halt) |=> busy_pull); // R4

  AST_LOCK_HOLDS: assert property (@(posedge bclk) disable iff (!init_n)
    (busy_pull && !lock_n) |=> busy_pull); // R6

  AST_PRIO_PASS: assert property (@(posedge bclk) disable iff (!init_n)
    !prio_out_n |-> (!prio_in_n && breq_n)); // R11

  AST_OWNER_NO_CBRQ: assert property (@(posedge bclk) disable iff (!init_n)
    busy_pull |-> !cbrq_pull); // R12

endmodule

bind mm_bus_arbiter mm_bus_arbiter_chk i_chk (
  .bclk(bclk), .init_n(init_n), .lock_n(lock_n), .prio_in_n(prio_in_n),
  .prio_out_n(prio_out_n), .breq_n(breq_n), .busy_in(busy_in),
  .busy_pull(busy_pull), .cbrq_in(cbrq_in), .cbrq_pull(cbrq_pull),
  .aen_n(aen_n), .st_halt(st_halt)
);

// File: tb/test_mm_bus_arbiter.sv
module test_mm_bus_arbiter;

  logic       clk = 1'b0;
  logic       init_n;
  logic [2:0] proc_status;
  logic       lock_n, crqlck_n, strap_iobus, strap_resident, strap_anyreq;
  logic       sysres_sel, prio_in_n;
  logic       ext_busy, ext_cbrq;
  logic       prio_out_n, breq_n, busy_pull, cbrq_pull, aen_n;
  logic       busy_in, cbrq_in;
  int         errors = 0;
  int         checks = 0;
  bit         done = 0;

  localparam logic [2:0] C_INTA = 3'b000, C_IORD = 3'b001, C_IOWR = 3'b010,
                         C_HALT = 3'b011, C_MRD = 3'b101, C_MWR = 3'b110,
                         C_PASS = 3'b111, C_FETCH = 3'b100;

  always #4 clk = ~clk;

  // wired-AND model of the two shared open-drain lines
  assign busy_in = !(busy_pull || ext_busy);
  assign cbrq_in = !(cbrq_pull || ext_cbrq);

  mm_bus_arbiter i_mm_bus_arbiter (
    .lclk(clk), .bclk(clk), .init_n(init_n), .proc_status(proc_status),
    .lock_n(lock_n), .crqlck_n(crqlck_n), .strap_iobus(strap_iobus),
    .strap_resident(strap_resident), .strap_anyreq(strap_anyreq),
    .sysres_sel(sysres_sel), .prio_in_n(prio_in_n), .prio_out_n(prio_out_n),
    .breq_n(breq_n), .busy_in(busy_in), .busy_pull(busy_pull),
    .cbrq_in(cbrq_in), .cbrq_pull(cbrq_pull), .aen_n(aen_n)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    init_n = 1'b0; proc_status = C_PASS; lock_n = 1'b1; crqlck_n = 1'b1;
    strap_iobus = 1'b0; strap_resident = 1'b0; strap_anyreq = 1'b0;
    sysres_sel = 1'b0; prio_in_n = 1'b1; ext_busy = 1'b0; ext_cbrq = 1'b0;
    tick(2);
    init_n = 1'b1;
    tick(1);
  endtask

  task automatic acquire();
    do_reset();
    prio_in_n = 1'b0;
    proc_status = C_MRD;
    tick(6);
    chk("R3", "acquire busy_pull", busy_pull, 1'b1);
  endtask

  task automatic t_reset();
    init_n = 1'b0;
    tick(1);
    chk("R1", "breq_n in init", breq_n, 1'b1);
    chk("R1", "aen_n in init", aen_n, 1'b1);
    do_reset();
    chk("R1", "breq_n after init", breq_n, 1'b1);
    chk("R1", "aen_n after init", aen_n, 1'b1);
    chk("R1", "busy_pull after init", busy_pull, 1'b0);
    chk("R1", "cbrq_pull after init", cbrq_pull, 1'b0);
    chk("R11", "prio_out_n no grant", prio_out_n, 1'b1);
    prio_in_n = 1'b0;
    tick(1);
    chk("R11", "prio_out_n passes grant when idle", prio_out_n, 1'b0);
  endtask

  task automatic t_request_grant();
    do_reset();
    proc_status = C_MRD;
    tick(6);
    chk("R2", "breq_n on memory cycle", breq_n, 1'b0);
    chk("R2", "cbrq_pull while waiting", cbrq_pull, 1'b1);
    chk("R2", "aen_n while waiting", aen_n, 1'b1);
    chk("R11", "prio_out_n while requesting", prio_out_n, 1'b1);
    ext_busy = 1'b1; prio_in_n = 1'b0;
    tick(3);
    chk("R3", "no take while busy low", busy_pull, 1'b0);
    chk("R11", "prio_out_n held while requesting", prio_out_n, 1'b1);
    ext_busy = 1'b0;
    tick(2);
    chk("R3", "take after busy frees", busy_pull, 1'b1);
    chk("R3", "aen_n low when owned", aen_n, 1'b0);
    chk("R12", "owner does not pull cbrq", cbrq_pull, 1'b0);
  endtask

  task automatic t_keep_and_halt();
    acquire();
    proc_status = C_PASS;
    tick(10);
    chk("R4", "keeps bus when passive", busy_pull, 1'b1);
    proc_status = C_HALT;
    tick(6);
    chk("R4", "releases on halt busy_pull", busy_pull, 1'b0);
    chk("R4", "releases on halt breq_n", breq_n, 1'b1);
    chk("R4", "releases on halt aen_n", aen_n, 1'b1);
  endtask

  task automatic t_lost_priority();
    acquire();
    proc_status = C_MWR;
    prio_in_n = 1'b1;
    tick(6);
    chk("R5", "keeps bus mid cycle", busy_pull, 1'b1);
    proc_status = C_PASS;
    tick(6);
    chk("R5", "releases at passive", busy_pull, 1'b0);
    chk("R5", "breq_n after release", breq_n, 1'b1);
  endtask

  task automatic t_lock();
    acquire();
    lock_n = 1'b0; prio_in_n = 1'b1; ext_cbrq = 1'b1; strap_anyreq = 1'b1;
    proc_status = C_PASS;
    tick(8);
    chk("R6", "locked owner keeps bus", busy_pull, 1'b1);
    lock_n = 1'b1;
    tick(2);
    chk("R6", "release once unlocked", busy_pull, 1'b0);
  endtask

  task automatic t_crqlck_anyreq();
    acquire();
    strap_anyreq = 1'b1; crqlck_n = 1'b0; ext_cbrq = 1'b1;
    proc_status = C_PASS;
    tick(6);
    chk("R7", "common request ignored under crqlck", busy_pull, 1'b1);
    chk("R12", "owner cbrq_pull", cbrq_pull, 1'b0);
    crqlck_n = 1'b1;
    tick(2);
    chk("R8", "any-request release at passive", busy_pull, 1'b0);
  endtask

  task automatic t_no_anyreq();
    acquire();
    strap_anyreq = 1'b0; ext_cbrq = 1'b1;
    proc_status = C_PASS;
    tick(8);
    chk("R8", "keeps bus across passive without any-request", busy_pull, 1'b1);
  endtask

  task automatic t_iobus();
    do_reset();
    strap_iobus = 1'b1; prio_in_n = 1'b0;
    proc_status = C_IORD;
    tick(6);
    chk("R9", "I/O read does not request", breq_n, 1'b1);
    proc_status = C_PASS; tick(4);
    proc_status = C_INTA; tick(6);
    chk("R9", "interrupt ack does not request", breq_n, 1'b1);
    proc_status = C_PASS; tick(4);
    proc_status = C_FETCH; tick(6);
    chk("R9", "memory fetch takes bus", busy_pull, 1'b1);
    proc_status = C_PASS; ext_cbrq = 1'b1;
    tick(6);
    chk("R9", "kept at passive (no any-request)", busy_pull, 1'b1);
    proc_status = C_IOWR;
    tick(6);
    chk("R9", "released during I/O cycle", busy_pull, 1'b0);
  endtask

  task automatic t_resident();
    do_reset();
    strap_resident = 1'b1; prio_in_n = 1'b0; sysres_sel = 1'b0;
    proc_status = C_MRD; tick(6);
    chk("R10", "resident access does not request", breq_n, 1'b1);
    proc_status = C_PASS; tick(4);
    sysres_sel = 1'b1;
    proc_status = C_MRD; tick(6);
    chk("R10", "system access takes bus", busy_pull, 1'b1);
    prio_in_n = 1'b1;
    tick(4);
    chk("R10", "kept while selected mid cycle", busy_pull, 1'b1);
    sysres_sel = 1'b0;
    tick(2);
    chk("R10", "released when deselected", busy_pull, 1'b0);
    do_reset();
    strap_resident = 1'b0; sysres_sel = 1'b0; prio_in_n = 1'b0;
    proc_status = C_MRD; tick(6);
    chk("R10", "select ignored when strap low", busy_pull, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_request_grant();
    t_keep_and_halt();
    t_lost_priority();
    t_lock();
    t_crqlck_anyreq();
    t_no_anyreq();
    t_iobus();
    t_resident();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule